// File: doc/BRIEF.md
# Shift-Register Clock Divider with Early Reload

This block divides its clock by a fixed ratio using a linear-feedback shift register in place of a binary adder. The register walks a maximal-length pseudorandom sequence of nonzero states. One state of that walk is chosen as the terminal state. When the block is enabled in that state, it pulses a terminal-count output for one cycle and reloads the all-ones start pattern on the next edge. The period is therefore exactly `DIV` enabled cycles for any `DIV` from 2 up to 2^W−1.

The feedback can be built in two ways. In the one-to-many form, the top bit is XORed into several stages. In the many-to-one form, several stages are XORed into the shift input. Both forms give a full-length cycle, but they visit the states in different orders. The terminal state is therefore worked out at elaboration by stepping the chosen form `DIV`−1 times from all ones. It is never written in by hand.

Other logic uses the block as a cheap prescaler or as a pseudorandom state source. An asynchronous active-low reset, released through a two-stage synchronizer, gives a known start. A synchronous clear restarts the sequence from within the running logic.

Top module: `lfsr_divider`

## Requirements
- R1: While `rst_n` is low, `state` is all ones and `tc` is low. Reset takes effect at once and is released through two register stages, so counting can resume from the third rising edge after `rst_n` rises.
- R2: With `STYLE` = one-to-many, an enabled step from a nonzero, non-terminal state s gives `{s[W-2:0],0} XOR (s[W-1] ? POLY : 0)`. Here `POLY` bit i is the coefficient of x^i, and x^W is implied (default x^4+x+1 is `4'b0011`).
- R3: With `STYLE` = many-to-one, an enabled step from a nonzero, non-terminal state s gives `{s[W-2:0], f}`. Here f is the XOR of `s[W-1-i]` over every i where `POLY[i]` is 1.
- R4: Starting from all ones with `en` high, `state` is all ones again after exactly `DIV` edges. For the defaults (W=4, one-to-many, `DIV`=12), the state after 11 edges is `4'h5`.
- R5: `tc` is high exactly when `en` is high, `clr` is low and `state` equals the terminal state. This gives one pulse per period.
- R6: When `en` is low and `clr` is low, `state` keeps its value across the edge and `tc` stays low.
- R7: When `clr` is high, the next edge loads all ones whether or not `en` is high. `tc` is low while `clr` is high.
- R8: If `state` is ever all zeros, the next enabled edge loads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous restart to all ones; takes priority over `en` |
| en | input | 1 | Count enable |
| state | output | W | Current shift-register contents |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
Two instances run side by side: the default one-to-many divider by 12 and a many-to-one width-6 divider by 35. Their sequences are compared edge by edge against bench models built from R2 and R3. A design with a wrong terminal state, for example one counted from the other feedback form, would wrap early or late and break the period and `tc` checks. The bench clears while disabled and while sitting on the terminal state, to catch an enable-before-clear priority error. It gates `en` while on the terminal state, to catch a `tc` that ignores enable. It forces the register to all zeros, so a missing lockup escape would leave `state` stuck at zero.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  typedef enum logic {
    FB_MANY_TO_ONE = 1'b0,
    FB_ONE_TO_MANY = 1'b1
  } fb_style_e;

  // One step of the register, widths up to 32, for constant evaluation.
  function automatic logic [31:0] lfsr_advance(input int w, input fb_style_e sty,
                                               input logic [31:0] poly,
                                               input logic [31:0] s);
    logic [31:0] r;
    logic        fb;
    r  = '0;
    fb = 1'b0;
    if (sty == FB_ONE_TO_MANY) begin
      fb   = s[w-1];
      r[0] = fb & poly[0];
      for (int i = 1; i < 32; i++) begin
        if (i < w) r[i] = s[i-1] ^ (fb & poly[i]);
      end
    end else begin
      for (int i = 0; i < 32; i++) begin
        if ((i < w) && poly[i]) fb = fb ^ s[w-1-i];
      end
      r[0] = fb;
      for (int i = 1; i < 32; i++) begin
        if (i < w) r[i] = s[i-1];
      end
    end
    return r;
  endfunction

  // State reached n-1 steps after the all-ones start pattern.
  function automatic logic [31:0] lfsr_terminal(input int w, input fb_style_e sty,
                                                input logic [31:0] poly, input int n);
    logic [31:0] s;
    s = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    for (int k = 1; k < n; k++) s = lfsr_advance(w, sty, poly, s);
    return s;
  endfunction

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/lfsr_next.sv
module lfsr_next
  import lfsr_div_pkg::*;
#(
  parameter int             W     = 4,
  parameter logic [W-1:0]   POLY  = 4'b0011,
  parameter fb_style_e      STYLE = FB_ONE_TO_MANY
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  if (STYLE == FB_ONE_TO_MANY) begin : g_one_to_many
    assign nxt = {cur[W-2:0], 1'b0} ^ (cur[W-1] ? POLY : '0);
  end else begin : g_many_to_one
    logic [W-1:0] tap_rev;
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign tap_rev[i] = POLY[W-1-i];
    end
    assign nxt = {cur[W-2:0], ^(cur & tap_rev)};
  end

  // R2 / R3: a primitive step never maps a live state into the lockup state
  always_comb begin
    if (cur != '0) begin
      p_keep_nonzero_r2: assert (nxt != '0)
        else $error("nonzero state stepped to zero");
    end
  end
endmodule

// File: rtl/lfsr_term_detect.sv
module lfsr_term_detect #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TERM = '0
) (
  input  logic [W-1:0] state,
  output logic         hit,
  output logic         zero
);
  assign hit  = (state == TERM);
  assign zero = (state == '0);
endmodule

// File: rtl/lfsr_divider.sv
module lfsr_divider
  import lfsr_div_pkg::*;
#(
  parameter int           W     = 4,
  parameter logic [W-1:0] POLY  = 4'b0011,
  parameter fb_style_e    STYLE = FB_ONE_TO_MANY,
  parameter int           DIV   = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] state,
  output logic         tc
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] TERM = W'(lfsr_terminal(W, STYLE, 32'(POLY), DIV));

  logic         rst_ok;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] step_nxt;
  logic         at_term;
  logic         at_zero;
  logic         load_en;

  lfsr_rst_sync u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_out (rst_ok)
  );

  lfsr_next #(.W(W), .POLY(POLY), .STYLE(STYLE)) u_step (
    .cur (state_q),
    .nxt (step_nxt)
  );

  lfsr_term_detect #(.W(W), .TERM(TERM)) u_det (
    .state (state_q),
    .hit   (at_term),
    .zero  (at_zero)
  );

  assign load_en = clr | en;

  always_comb begin
    state_d = state_q;
    if (clr)                     state_d = ONES;
    else if (at_term || at_zero) state_d = ONES;
    else                         state_d = step_nxt;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      state_q <= ONES;
    else if (load_en) state_q <= state_d;
  end

  assign state = state_q;
  assign tc    = en & ~clr & at_term;

  // R4: a terminal pulse is followed by the start pattern
  p_reload_after_tc_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    tc |=> (state_q == ONES));

  // R5: never two pulses in a row
  p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    tc |=> !tc);

  // R6: idle cycles keep the state
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!en && !clr) |=> $stable(state_q));

  // R7: clear restarts regardless of enable
  p_clear_loads_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    clr |=> (state_q == ONES));

  // R8: lockup state escapes on an enabled edge
  p_zero_escape_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (at_zero && en) |=> (state_q == ONES));
endmodule

// File: tb/sim_lfsr_divider.sv
`timescale 1ns/1ps
module sim_lfsr_divider;
  import lfsr_div_pkg::*;

  localparam int         WA = 4;
  localparam int         NA = 12;
  localparam logic [3:0] PA = 4'b0011;
  localparam int         WB = 6;
  localparam int         NB = 35;
  localparam logic [5:0] PB = 6'b000011;

  logic clk = 1'b0;
  logic rst_n, clr, en;
  logic [3:0] st_a;
  logic       tc_a;
  logic [5:0] st_b;
  logic       tc_b;

  int total = 0;
  int bad   = 0;
  int pulses_a = 0;
  logic [3:0] ma, term_a;
  logic [5:0] mb, term_b;

  always #10 clk = ~clk;

  lfsr_divider #(.W(WA), .POLY(PA), .STYLE(FB_ONE_TO_MANY), .DIV(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .state(st_a), .tc(tc_a));

  lfsr_divider #(.W(WB), .POLY(PB), .STYLE(FB_MANY_TO_ONE), .DIV(NB)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .state(st_b), .tc(tc_b));

  // Models from R2 and R3
  function automatic logic [3:0] step_a(input logic [3:0] s);
    return {s[2:0], 1'b0} ^ (s[3] ? PA : 4'b0000);
  endfunction

  function automatic logic [5:0] step_b(input logic [5:0] s);
    return {s[4:0], s[5] ^ s[4]};
  endfunction

  function automatic logic [3:0] upd_a(input logic [3:0] m, input logic e, input logic c);
    if (c) return 4'hF;
    if (!e) return m;
    if (m == 4'h0 || m == term_a) return 4'hF;
    return step_a(m);
  endfunction

  function automatic logic [5:0] upd_b(input logic [5:0] m, input logic e, input logic c);
    if (c) return 6'h3F;
    if (!e) return m;
    if (m == 6'h00 || m == term_b) return 6'h3F;
    return step_b(m);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; drives, checks tc, steps one edge, checks state.
  task automatic tick(input logic e, input logic c);
    en  = e;
    clr = c;
    #1;
    chk("R5", "tc_a", int'(tc_a), int'(e && !c && ma == term_a));
    chk("R5", "tc_b", int'(tc_b), int'(e && !c && mb == term_b));
    if (tc_a) pulses_a++;
    @(posedge clk);
    ma = upd_a(ma, e, c);
    mb = upd_b(mb, e, c);
    @(negedge clk);
    chk("R2", "state_a", int'(st_a), int'(ma));
    chk("R3", "state_b", int'(st_b), int'(mb));
  endtask

  task automatic t_reset_r1();
    en = 1'b1; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "state_a in reset", int'(st_a), 'hF);
    chk("R1", "state_b in reset", int'(st_b), 'h3F);
    chk("R1", "tc_a in reset", int'(tc_a), 0);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "state_a after release", int'(st_a), 'hF);
    ma = 4'hF; mb = 6'h3F;
  endtask

  task automatic t_period_r4();
    tick(1'b0, 1'b1);
    pulses_a = 0;
    for (int i = 0; i < NB; i++) begin
      tick(1'b1, 1'b0);
      if (i == NA - 2) chk("R4", "terminal of default", int'(st_a), 'h5);
      if (i == NA - 1) chk("R4", "state_a after DIV edges", int'(st_a), 'hF);
      if (i == 2*NA - 1) chk("R5", "pulses in two periods", pulses_a, 2);
    end
    chk("R4", "state_b after DIV edges", int'(st_b), 'h3F);
  endtask

  task automatic t_enable_r6();
    tick(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) tick(i % 3 != 0, 1'b0);
    while (ma != term_a) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R6", "held terminal state_a", int'(st_a), int'(term_a));
    chk("R6", "tc_a while disabled", int'(tc_a), 0);
  endtask

  task automatic t_clear_r7();
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    chk("R7", "clear while disabled", int'(st_a), 'hF);
    while (ma != term_a) tick(1'b1, 1'b0);
    en = 1'b1; clr = 1'b1; #1;
    chk("R7", "tc_a low during clear", int'(tc_a), 0);
    tick(1'b1, 1'b1);
    chk("R7", "clear on terminal", int'(st_a), 'hF);
    chk("R7", "clear state_b", int'(st_b), 'h3F);
  endtask

  task automatic t_zero_r8();
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    force u0.state_q = 4'h0;
    force u1.state_q = 6'h00;
    #1;
    release u0.state_q;
    release u1.state_q;
    ma = 4'h0; mb = 6'h00;
    chk("R8", "forced zero visible", int'(st_a), 0);
    tick(1'b0, 1'b0);
    chk("R8", "zero held while idle", int'(st_b), 0);
    tick(1'b1, 1'b0);
    chk("R8", "escape state_a", int'(st_a), 'hF);
    chk("R8", "escape state_b", int'(st_b), 'h3F);
  endtask

  task automatic t_async_r1();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    en = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "async reset state_a", int'(st_a), 'hF);
    chk("R1", "async reset state_b", int'(st_b), 'h3F);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ma = 4'hF; mb = 6'h3F;
    tick(1'b1, 1'b0);
    chk("R1", "counting resumes", int'(st_a), 'hD);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; en = 1'b0;
    ma = 4'hF; mb = 6'h3F;
    term_a = 4'hF;
    for (int k = 1; k < NA; k++) term_a = step_a(term_a);
    term_b = 6'h3F;
    for (int k = 1; k < NB; k++) term_b = step_b(term_b);
    @(negedge clk);
    t_reset_r1();
    t_period_r4();
    t_enable_r6();
    t_clear_r7();
    t_zero_r8();
    t_async_r1();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule